// File: doc/BRIEF.md
# Partitionable SIMD Arithmetic/Logic Unit

This block is a 32-bit arithmetic/logic unit whose adder can be split into independent lanes. A gauge input selects the partition: one 32-bit lane, two 16-bit lanes, or four 8-bit lanes. All lanes run the same opcode in the same cycle. Each lane computes over its own slice of the two packed operands. No carry passes from one lane into the next.

The carry chain is built from 8-bit groups. At every group edge that starts a lane, the carry from the group below is replaced by a carry injected for that lane. The injected carry is zero for add, one for subtract, and the shared external carry-in for add-with-carry. Each lane reports its own carry-out, zero, negative and signed-overflow flags, computed over that lane's bits only.

Results and flags pass through one register stage. A new operation is accepted on every clock in every gauge.

Top module: `mg_alu`

## Requirements
- R1: The gauge encoding is: 0 gives one 32-bit lane, 1 gives two 16-bit lanes, 2 gives four 8-bit lanes. Code 3 behaves exactly like code 0. Lane n occupies result bits [n*w +: w], where w is the lane width.
- R2: Opcode 0 (add) produces, in each active lane, the sum of the operand slices modulo 2^w. No carry enters a lane from the lane below it.
- R3: Opcode 1 (add with carry) adds the external carry-in into every active lane at that lane's lowest bit.
- R4: Opcode 2 (subtract) produces, in each lane, operand A minus operand B modulo 2^w. This is done by adding the inverted B slice plus an injected carry of one per lane.
- R5: Opcodes 3, 4 and 5 produce bitwise AND, OR and XOR. The results are identical in every gauge, and the carry and overflow flags of every lane are 0.
- R6: For opcodes 0 to 2, the carry flag of an active lane is the carry out of that lane's top bit. For subtract this carry is 1 exactly when A is greater than or equal to B, both taken unsigned.
- R7: The zero flag of an active lane is 1 exactly when that lane's result bits are all 0.
- R8: The negative flag of an active lane equals the top bit of that lane's result.
- R9: For opcodes 0 to 2, the overflow flag of an active lane is 1 when the two effective addends share a sign bit and the lane's result has the other sign.
- R10: Flag bits of lanes that do not exist in the current gauge read 0. Flag bit n belongs to lane n.
- R11: Outputs show the operation presented at a clock edge from that edge until the next one. Back-to-back operations are all accepted.
- R12: While the active-low reset is asserted, the result and all flags are 0.
- R13: Opcodes 6 and 7 give a zero result. Active lanes then show zero=1, and their carry, negative and overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | Packed operand A |
| opB | input | 32 | Packed operand B |
| opcode | input | 3 | Operation shared by all lanes |
| carryIn | input | 1 | External carry for add-with-carry |
| gauge | input | 2 | Lane partition select |
| result | output | 32 | Packed registered result |
| laneCarry | output | 4 | Carry-out per lane |
| laneZero | output | 4 | Zero flag per lane |
| laneNeg | output | 4 | Negative flag per lane |
| laneOvf | output | 4 | Signed overflow flag per lane |

## Verification
Two things can happen at the same group edge in one cycle. The lower lane can produce a carry-out. The upper lane can also need its own injected carry. A correct design must report the first as a flag and use only the second.

The bench provokes this collision by sweeping operand pairs such as all-ones, 0x7F and 0x80 byte patterns. Those pairs drive every lane to carry and overflow at once, under add, add-with-carry and subtract, in every gauge and with both carry-in values.

Each lane's result and flags are judged against per-lane arithmetic done in the bench on the isolated slices. Any carry leaking across a boundary therefore shows up as a mismatch in the neighbouring lane.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int MG_WIDTH  = 32;
  localparam int MG_GROUP  = 8;
  localparam int MG_GROUPS = MG_WIDTH / MG_GROUP;
  localparam int MG_LOGG   = $clog2(MG_GROUPS);
  localparam int MG_SHW    = MG_LOGG + 1;

  typedef enum logic [1:0] {
    GAUGE_WIDE  = 2'd0,
    GAUGE_HALF  = 2'd1,
    GAUGE_BYTE  = 2'd2,
    GAUGE_SPARE = 2'd3
  } gauge_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_EXT  = 2'd2
  } cin_sel_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } log_fn_e;

  typedef struct packed {
    logic                 arith;
    logic                 invertB;
    cin_sel_e             cinSel;
    log_fn_e              logicFn;
    logic                 forceZero;
    logic [MG_GROUPS-1:0] laneStart;
    logic [MG_GROUPS-1:0] laneTop;
    logic [MG_SHW-1:0]    laneShift;
  } mg_ctrl_t;
endpackage

// File: rtl/mg_ctrl.sv
module mg_ctrl
  import mg_pkg::*;
#(
  parameter int GROUPS = MG_GROUPS
) (
  input  logic [2:0] opcode,
  input  logic [1:0] gauge,
  output mg_ctrl_t   ctrl
);
  localparam int LOGG = $clog2(GROUPS);

  always_comb begin
    int lanesLog2;
    int shift;
    int gpl;
    ctrl = '0;
    case (op_e'(opcode))
      OP_ADD: begin ctrl.arith = 1'b1; ctrl.cinSel = CIN_ZERO; end
      OP_ADC: begin ctrl.arith = 1'b1; ctrl.cinSel = CIN_EXT;  end
      OP_SUB: begin ctrl.arith = 1'b1; ctrl.cinSel = CIN_ONE; ctrl.invertB = 1'b1; end
      OP_AND: ctrl.logicFn = LOG_AND;
      OP_OR:  ctrl.logicFn = LOG_OR;
      OP_XOR: ctrl.logicFn = LOG_XOR;
      default: ctrl.forceZero = 1'b1;
    endcase
    case (gauge_e'(gauge))
      GAUGE_HALF: lanesLog2 = 1;
      GAUGE_BYTE: lanesLog2 = 2;
      default:    lanesLog2 = 0;
    endcase
    if (lanesLog2 > LOGG) lanesLog2 = LOGG;
    shift = LOGG - lanesLog2;
    gpl   = 1 << shift;
    ctrl.laneShift = MG_SHW'(shift);
    for (int g = 0; g < GROUPS; g++) begin
      ctrl.laneStart[g] = ((g % gpl) == 0);
      ctrl.laneTop[g]   = ((g % gpl) == gpl - 1);
    end
  end
endmodule

// File: rtl/mg_datapath.sv
module mg_datapath
  import mg_pkg::*;
#(
  parameter int WIDTH = MG_WIDTH,
  parameter int GROUP = MG_GROUP
) (
  input  logic [WIDTH-1:0]       a,
  input  logic [WIDTH-1:0]       b,
  input  logic                   carryIn,
  input  mg_ctrl_t               ctrl,
  output logic [WIDTH-1:0]       sum,
  output logic [WIDTH/GROUP-1:0] laneC,
  output logic [WIDTH/GROUP-1:0] laneZ,
  output logic [WIDTH/GROUP-1:0] laneN,
  output logic [WIDTH/GROUP-1:0] laneV
);
  localparam int GROUPS = WIDTH / GROUP;

  always_comb begin
    logic             inj;
    logic             chain;
    logic             cg;
    logic             zAcc;
    logic [GROUP-1:0] aG;
    logic [GROUP-1:0] bG;
    logic [GROUP-1:0] rG;
    logic [GROUP-1:0] lg;
    logic [GROUP:0]   sG;
    int               idx;
    sum   = '0;
    laneC = '0;
    laneZ = '0;
    laneN = '0;
    laneV = '0;
    chain = 1'b0;
    zAcc  = 1'b1;
    case (ctrl.cinSel)
      CIN_ONE: inj = 1'b1;
      CIN_EXT: inj = carryIn;
      default: inj = 1'b0;
    endcase
    for (int g = 0; g < GROUPS; g++) begin
      aG = a[g*GROUP +: GROUP];
      bG = ctrl.invertB ? ~b[g*GROUP +: GROUP] : b[g*GROUP +: GROUP];
      // lane boundary: drop the lower group's carry, inject the lane's own
      cg = ctrl.laneStart[g] ? inj : chain;
      sG = {1'b0, aG} + {1'b0, bG} + {{GROUP{1'b0}}, cg};
      case (ctrl.logicFn)
        LOG_OR:  lg = aG | bG;
        LOG_XOR: lg = aG ^ bG;
        default: lg = aG & bG;
      endcase
      rG = ctrl.arith ? sG[GROUP-1:0] : lg;
      if (ctrl.forceZero) rG = '0;
      chain = sG[GROUP];
      zAcc  = (ctrl.laneStart[g] ? 1'b1 : zAcc) & (rG == '0);
      sum[g*GROUP +: GROUP] = rG;
      if (ctrl.laneTop[g]) begin
        idx        = g >> ctrl.laneShift;
        laneC[idx] = ctrl.arith & sG[GROUP];
        laneZ[idx] = zAcc;
        laneN[idx] = rG[GROUP-1];
        laneV[idx] = ctrl.arith & (aG[GROUP-1] == bG[GROUP-1]) & (rG[GROUP-1] != aG[GROUP-1]);
      end
    end
  end
endmodule

// File: rtl/mg_alu.sv
module mg_alu
  import mg_pkg::*;
#(
  parameter int WIDTH = MG_WIDTH,
  parameter int GROUP = MG_GROUP
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH-1:0]       opA,
  input  logic [WIDTH-1:0]       opB,
  input  logic [2:0]             opcode,
  input  logic                   carryIn,
  input  logic [1:0]             gauge,
  output logic [WIDTH-1:0]       result,
  output logic [WIDTH/GROUP-1:0] laneCarry,
  output logic [WIDTH/GROUP-1:0] laneZero,
  output logic [WIDTH/GROUP-1:0] laneNeg,
  output logic [WIDTH/GROUP-1:0] laneOvf
);
  localparam int LANES = WIDTH / GROUP;

  mg_ctrl_t         ctrl;
  logic [WIDTH-1:0] sumD;
  logic [LANES-1:0] cD, zD, nD, vD;
  logic [1:0]       gaugeQ;
  logic [2:0]       opQ;

  mg_ctrl #(.GROUPS(LANES)) i_ctrl (
    .opcode(opcode),
    .gauge (gauge),
    .ctrl  (ctrl)
  );

  mg_datapath #(.WIDTH(WIDTH), .GROUP(GROUP)) i_dp (
    .a      (opA),
    .b      (opB),
    .carryIn(carryIn),
    .ctrl   (ctrl),
    .sum    (sumD),
    .laneC  (cD),
    .laneZ  (zD),
    .laneN  (nD),
    .laneV  (vD)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      laneCarry <= '0;
      laneZero  <= '0;
      laneNeg   <= '0;
      laneOvf   <= '0;
      gaugeQ    <= '0;
      opQ       <= '0;
    end else begin
      result    <= sumD;
      laneCarry <= cD;
      laneZero  <= zD;
      laneNeg   <= nD;
      laneOvf   <= vD;
      gaugeQ    <= gauge;
      opQ       <= opcode;
    end
  end

  // R10: only lane 0 exists in the wide gauge
  assert_unused_lanes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (gaugeQ == GAUGE_WIDE || gaugeQ == GAUGE_SPARE) |->
      (laneCarry[LANES-1:1] == '0 && laneZero[LANES-1:1] == '0 &&
       laneNeg[LANES-1:1] == '0 && laneOvf[LANES-1:1] == '0));

  // R5: logic ops never raise carry or overflow
  assert_logic_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_AND || opQ == OP_OR || opQ == OP_XOR) |->
      (laneCarry == '0 && laneOvf == '0));

  // R8: wide-gauge sign flag follows the result's top bit
  assert_wide_neg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (gaugeQ == GAUGE_WIDE) |-> (laneNeg[0] == result[WIDTH-1]));

  for (genvar l = 0; l < LANES; l++) begin : g_laneChk
    // R7: per-lane zero flag agrees with that lane's result bits
    assert_byte_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
      (gaugeQ == GAUGE_BYTE) |-> (laneZero[l] == (result[l*GROUP +: GROUP] == '0)));
    // R8: per-lane sign flag agrees with that lane's top bit
    assert_byte_neg_R8: assert property (@(posedge clk) disable iff (!rstN)
      (gaugeQ == GAUGE_BYTE) |-> (laneNeg[l] == result[l*GROUP + GROUP - 1]));
  end
endmodule

// File: tb/test_mg_alu.sv
`timescale 1ns/1ps
module test_mg_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  opcode = '0;
  logic        carryIn = 1'b0;
  logic [1:0]  gauge = '0;
  logic [31:0] result;
  logic [3:0]  laneCarry, laneZero, laneNeg, laneOvf;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  logic        pending = 0;
  logic [31:0] eR;
  logic [3:0]  eC, eZ, eN, eV;
  logic [2:0]  eOp;
  logic [1:0]  eG;

  always #4 clk = ~clk;

  mg_alu i_mg_alu (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opcode(opcode),
    .carryIn(carryIn), .gauge(gauge), .result(result),
    .laneCarry(laneCarry), .laneZero(laneZero), .laneNeg(laneNeg), .laneOvf(laneOvf)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] pat(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'hFFFF_FFFF;
      2: return 32'h8080_8080;  3: return 32'h7F7F_7F7F;
      4: return 32'h0001_0001;  5: return 32'h0101_0101;
      6: return 32'hFEFE_FEFE;  7: return 32'h8000_8000;
      8: return 32'h7FFF_7FFF;  9: return 32'h1234_5678;
      10: return 32'h89AB_CDEF; 11: return 32'h0000_FFFF;
      12: return 32'hFFFF_0000; 13: return 32'h00FF_00FF;
      14: return 32'h55AA_33CC; default: return 32'hC3A5_5A3C;
    endcase
  endfunction

  // per-lane arithmetic on isolated slices
  task automatic model(input logic [31:0] a, b, input logic [2:0] op,
                       input logic ci, input logic [1:0] g,
                       output logic [31:0] r, output logic [3:0] c, z, n, v);
    int k, w;
    longint unsigned mask, la, lb, bb, s, rl, cin;
    k = (g == 2'd1) ? 2 : (g == 2'd2) ? 4 : 1;
    w = 32 / k;
    mask = (longint'(1) << w) - 1;
    r = '0; c = '0; z = '0; n = '0; v = '0;
    for (int l = 0; l < k; l++) begin
      la = (longint'(a) >> (l*w)) & mask;
      lb = (longint'(b) >> (l*w)) & mask;
      bb = lb; cin = 0;
      if (op <= 3'd2) begin
        if (op == 3'd1) cin = longint'(ci);
        if (op == 3'd2) begin bb = ~lb & mask; cin = 1; end
        s  = la + bb + cin;
        rl = s & mask;
        c[l] = s[w];
        v[l] = (((la ^ rl) & (bb ^ rl)) >> (w-1)) & 1;
      end else if (op == 3'd3) rl = la & lb;
      else if (op == 3'd4) rl = la | lb;
      else if (op == 3'd5) rl = la ^ lb;
      else rl = 0;
      z[l] = (rl == 0);
      n[l] = (rl >> (w-1)) & 1;
      r = r | 32'(rl << (l*w));
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic string resTag(logic [2:0] op, logic [1:0] g);
    if (g == 2'd3) return "R1";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4, 3'd5: return "R5";
      default: return "R13";
    endcase
  endfunction

  task automatic compareAll();
    int k;
    k = (eG == 2'd1) ? 2 : (eG == 2'd2) ? 4 : 1;
    chk(resTag(eOp, eG), "result", result, eR);
    for (int l = 0; l < 4; l++) begin
      chk(l >= k ? "R10" : "R6", "carry", 32'(laneCarry[l]), 32'(eC[l]));
      chk(l >= k ? "R10" : "R7", "zero",  32'(laneZero[l]),  32'(eZ[l]));
      chk(l >= k ? "R10" : "R8", "neg",   32'(laneNeg[l]),   32'(eN[l]));
      chk(l >= k ? "R10" : "R9", "ovf",   32'(laneOvf[l]),   32'(eV[l]));
    end
  endtask

  task automatic step(logic [31:0] a, b, logic [2:0] op, logic ci, logic [1:0] g);
    @(negedge clk);
    if (pending) compareAll();
    opA = a; opB = b; opcode = op; carryIn = ci; gauge = g;
    model(a, b, op, ci, g, eR, eC, eZ, eN, eV);
    eOp = op; eG = g;
    pending = 1;
  endtask

  initial begin
    opA = 32'hFFFF_FFFF; opB = 32'h1; opcode = 3'd0;
    repeat (3) @(negedge clk);
    // R12: outputs cleared under reset
    chk("R12", "reset result", result, 32'h0);
    chk("R12", "reset flags", {16'h0, laneCarry, laneZero, laneNeg, laneOvf}, 32'h0);
    rstN = 1'b1;

    for (int g = 0; g < 4; g++)
      for (int op = 0; op < 8; op++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              step(pat(i), pat(j), 3'(op), 1'(ci), 2'(g));
    @(negedge clk);
    compareAll();
    pending = 0;

    // R11: back-to-back operations each visible for exactly one cycle
    opA = 32'd1; opB = 32'd1; opcode = 3'd0; gauge = 2'd0;
    @(negedge clk);
    chk("R11", "first of pair", result, 32'd2);
    opA = 32'd10; opB = 32'd3; opcode = 3'd2;
    @(negedge clk);
    chk("R11", "second of pair", result, 32'd7);

    // R12: reset asserted mid-run clears outputs
    opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF; opcode = 3'd0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R12", "mid-run reset result", result, 32'h0);
    chk("R12", "mid-run reset flags", {16'h0, laneCarry, laneZero, laneNeg, laneOvf}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule